// File: doc/BRIEF.md
# Flash Control Window Decoder

This block is the bus-facing front end of an embedded flash module. A one-bit access-control flag decides what the module's address window shows. With the flag at 1, bus reads go straight to the memory array and complete in the same cycle. With the flag at 0, a bank of four 16-bit control registers takes over the whole window. The two lowest address bits pick a register, so the bank repeats at every group of four addresses.

The control bank holds a segment-control word, a test word, a write-address word and a write-data word. The block decodes the segment-control word into two sets of outputs for the program and erase sequencers. One is an eight-bit segment-enable vector. The other is a two-bit read reference mode for the array model. The block also screens program-pulse requests from the sequencer. A request becomes a pulse only when the segment that the write-address register points into is enabled. Otherwise the request is flagged as illegal.

Top module: `flash_regif`

## Requirements
- R1: After reset the access flag is 1 (array view) and all four control registers read 0, so `seg_en`, `read_mode`, `test_ctl`, `wr_addr` and `wr_data` are 0. `pulse_fire` and `pulse_bad` are also 0.
- R2: When `acc_wr` is high at a clock edge, the access flag takes `acc_val`, and `arr_mode` shows the new value from that edge on.
- R3: In array view, a bus read (`bus_sel`=1, `bus_we`=0) raises `arr_re` and returns `arr_rdata` on `bus_rdata` in the same cycle, with zero wait states.
- R4: In register view, `bus_addr[1:0]` selects the register: 0 is segment control, 1 is test, 2 is write address and 3 is write data. The upper address bits are ignored, so the bank repeats across the window. In this view `arr_re` stays 0.
- R5: In register view, a bus write loads all 16 bits of the selected register at the clock edge. A read of that register in a later cycle returns the value, and `wr_data`, `wr_addr` and `test_ctl` follow their registers.
- R6: `seg_en[i]` is bit 8+i of the segment-control register, for segments 0 to 7.
- R7: `read_mode` is bits 4:3 of the segment-control register. The codes are 00 standard, 01 verify-zeros, 10 verify-ones and 11 inverse-erase.
- R8: A bus write made in array view changes no control register.
- R9: The addressed segment is `wr_addr[13:11]`. A `pulse_req` while that segment's enable bit is 1 gives `pulse_fire`=1 and `pulse_bad`=0 for one cycle after the edge.
- R10: A `pulse_req` while the addressed segment's enable bit is 0 gives `pulse_bad`=1 and `pulse_fire`=0 for one cycle after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_wr | input | 1 | Load strobe for the access flag |
| acc_val | input | 1 | New access flag value (1 array, 0 registers) |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | Bus access is a write |
| bus_addr | input | 14 | Word address within the module window |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Bus read data, same cycle |
| arr_rdata | input | 16 | Data from the array model |
| arr_re | output | 1 | Array read enable |
| arr_mode | output | 1 | Current access flag |
| read_mode | output | 2 | Read reference code for the array |
| seg_en | output | 8 | Segment enable vector |
| test_ctl | output | 16 | Test register contents |
| wr_addr | output | 14 | Write-address register contents |
| wr_data | output | 16 | Write-data register contents |
| pulse_req | input | 1 | Program-pulse request from the sequencer |
| pulse_fire | output | 1 | Accepted program pulse |
| pulse_bad | output | 1 | Rejected pulse: addressed segment disabled |

## Verification
The register bank is reached through several aliased addresses, some with high address bits set and some near the top of the window. Each read-back must then depend only on the two low bits. The segment-control word is written with several patterns that give different `read_mode` codes and an asymmetric enable byte. This shows whether the field positions are reversed or shifted. Program-pulse requests are aimed at one segment whose bit is set and one whose bit is clear, which separates accepted pulses from illegal ones. Array-view reads with a distinct array word, and array-view writes aimed at the data register, show that the flag actually switches the decode.

// File: rtl/flash_regif_pkg.sv
package flash_regif_pkg;

    localparam int REG_W       = 16;
    localparam int NUM_REGS    = 4;
    localparam int SEG_LSB     = 8;
    localparam int RDMODE_LSB  = 3;

    typedef enum logic [1:0] {
        OFS_CTL  = 2'd0,
        OFS_TST  = 2'd1,
        OFS_WADR = 2'd2,
        OFS_WDAT = 2'd3
    } reg_ofs_e;

    typedef enum logic [1:0] {
        RD_STANDARD = 2'd0,
        RD_VERIFY0  = 2'd1,
        RD_VERIFY1  = 2'd2,
        RD_INVERASE = 2'd3
    } rd_mode_e;

    typedef struct packed {
        logic [REG_W-1:0] ctl;
        logic [REG_W-1:0] tst;
        logic [REG_W-1:0] wadr;
        logic [REG_W-1:0] wdat;
        logic             acc;
        logic             fire;
        logic             bad;
    } bank_t;

endpackage

// File: rtl/flash_regif_decode.sv
module flash_regif_decode
    import flash_regif_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              acc_q,
    output logic [NUM_REGS-1:0] wr_stb,
    output reg_ofs_e          rd_ofs,
    output logic              arr_re
);

    logic reg_write;

    assign reg_write = bus_sel && bus_we && !acc_q;
    assign rd_ofs    = reg_ofs_e'(bus_addr[1:0]);
    assign arr_re    = bus_sel && !bus_we && acc_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_stb
        assign wr_stb[g] = reg_write && (bus_addr[1:0] == 2'(g));
    end

endmodule

// File: rtl/flash_regif_pulse.sv
module flash_regif_pulse #(
    parameter int ADDR_W  = 14,
    parameter int NUM_SEG = 8
) (
    input  logic               pulse_req,
    input  logic [NUM_SEG-1:0] seg_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    output logic               fire_d,
    output logic               bad_d
);

    localparam int SEG_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1;

    logic [SEG_W-1:0] seg_idx;
    logic             seg_ok;

    assign seg_idx = wr_addr[ADDR_W-1 -: SEG_W];
    assign seg_ok  = seg_en[seg_idx];
    assign fire_d  = pulse_req && seg_ok;
    assign bad_d   = pulse_req && !seg_ok;

endmodule

// File: rtl/flash_regif_bank.sv
module flash_regif_bank
    import flash_regif_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_wr,
    input  logic                acc_val,
    input  logic [NUM_REGS-1:0] wr_stb,
    input  logic [REG_W-1:0]    wdata,
    input  logic                fire_d,
    input  logic                bad_d,
    output bank_t               st_q
);

    bank_t st_d;

    always_comb begin
        st_d      = st_q;
        st_d.fire = fire_d;
        st_d.bad  = bad_d;
        if (acc_wr) begin
            st_d.acc = acc_val;
        end
        if (wr_stb[OFS_CTL]) begin
            st_d.ctl = wdata;
        end
        if (wr_stb[OFS_TST]) begin
            st_d.tst = wdata;
        end
        if (wr_stb[OFS_WADR]) begin
            st_d.wadr = wdata;
        end
        if (wr_stb[OFS_WDAT]) begin
            st_d.wdat = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.acc <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/flash_regif.sv
module flash_regif
    import flash_regif_pkg::*;
#(
    parameter int ADDR_W  = 14,
    parameter int NUM_SEG = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_wr,
    input  logic               acc_val,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic [REG_W-1:0]   arr_rdata,
    output logic               arr_re,
    output logic               arr_mode,
    output logic [1:0]         read_mode,
    output logic [NUM_SEG-1:0] seg_en,
    output logic [REG_W-1:0]   test_ctl,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [REG_W-1:0]   wr_data,
    input  logic               pulse_req,
    output logic               pulse_fire,
    output logic               pulse_bad
);

    bank_t               st_q;
    logic [NUM_REGS-1:0] wr_stb;
    reg_ofs_e            rd_ofs;
    logic                fire_d;
    logic                bad_d;
    logic [REG_W-1:0]    reg_rdata;

    flash_regif_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .acc_q    (st_q.acc),
        .wr_stb   (wr_stb),
        .rd_ofs   (rd_ofs),
        .arr_re   (arr_re)
    );

    flash_regif_pulse #(.ADDR_W(ADDR_W), .NUM_SEG(NUM_SEG)) u_pls (
        .pulse_req (pulse_req),
        .seg_en    (seg_en),
        .wr_addr   (wr_addr),
        .fire_d    (fire_d),
        .bad_d     (bad_d)
    );

    flash_regif_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_wr  (acc_wr),
        .acc_val (acc_val),
        .wr_stb  (wr_stb),
        .wdata   (bus_wdata),
        .fire_d  (fire_d),
        .bad_d   (bad_d),
        .st_q    (st_q)
    );

    always_comb begin
        unique case (rd_ofs)
            OFS_CTL:  reg_rdata = st_q.ctl;
            OFS_TST:  reg_rdata = st_q.tst;
            OFS_WADR: reg_rdata = st_q.wadr;
            default:  reg_rdata = st_q.wdat;
        endcase
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            bus_rdata = st_q.acc ? arr_rdata : reg_rdata;
        end
    end

    assign arr_mode   = st_q.acc;
    assign read_mode  = st_q.ctl[RDMODE_LSB +: 2];
    assign seg_en     = st_q.ctl[SEG_LSB +: NUM_SEG];
    assign test_ctl   = st_q.tst;
    assign wr_addr    = st_q.wadr[ADDR_W-1:0];
    assign wr_data    = st_q.wdat;
    assign pulse_fire = st_q.fire;
    assign pulse_bad  = st_q.bad;

endmodule

// File: rtl/flash_regif_chk.sv
module flash_regif_chk #(
    parameter int ADDR_W  = 14,
    parameter int NUM_SEG = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_wr,
    input logic               acc_val,
    input logic               bus_sel,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [15:0]        bus_wdata,
    input logic [15:0]        bus_rdata,
    input logic [15:0]        arr_rdata,
    input logic               arr_re,
    input logic               arr_mode,
    input logic [1:0]         read_mode,
    input logic [NUM_SEG-1:0] seg_en,
    input logic [15:0]        test_ctl,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [15:0]        wr_data,
    input logic               pulse_req,
    input logic               pulse_fire,
    input logic               pulse_bad
);

    localparam int SEG_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1;

    logic seg_hit;
    assign seg_hit = seg_en[wr_addr[ADDR_W-1 -: SEG_W]];

    assert_mode_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> arr_mode == $past(acc_val));

    assert_arr_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && arr_mode) |-> (arr_re && bus_rdata == arr_rdata));

    assert_no_arr_re_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !arr_mode |-> !arr_re);

    assert_wdat_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && !arr_mode && bus_addr[1:0] == 2'd3)
        |=> wr_data == $past(bus_wdata));

    assert_arr_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && arr_mode)
        |=> ($stable(seg_en) && $stable(read_mode) && $stable(test_ctl)
             && $stable(wr_addr) && $stable(wr_data)));

    assert_pulse_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_req && seg_hit) |=> (pulse_fire && !pulse_bad));

    assert_pulse_bad_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_req && !seg_hit) |=> (pulse_bad && !pulse_fire));

    assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pulse_fire, pulse_bad}) <= 1);

endmodule

bind flash_regif flash_regif_chk #(.ADDR_W(ADDR_W), .NUM_SEG(NUM_SEG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_wr     (acc_wr),
    .acc_val    (acc_val),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .arr_rdata  (arr_rdata),
    .arr_re     (arr_re),
    .arr_mode   (arr_mode),
    .read_mode  (read_mode),
    .seg_en     (seg_en),
    .test_ctl   (test_ctl),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .pulse_req  (pulse_req),
    .pulse_fire (pulse_fire),
    .pulse_bad  (pulse_bad)
);

// File: tb/sim_flash_regif.sv
module sim_flash_regif;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_wr = 1'b0;
    logic        acc_val = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [13:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] arr_rdata = '0;
    logic        arr_re;
    logic        arr_mode;
    logic [1:0]  read_mode;
    logic [7:0]  seg_en;
    logic [15:0] test_ctl;
    logic [13:0] wr_addr;
    logic [15:0] wr_data;
    logic        pulse_req = 1'b0;
    logic        pulse_fire;
    logic        pulse_bad;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    flash_regif u0 (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_val(acc_val),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .arr_rdata(arr_rdata),
        .arr_re(arr_re), .arr_mode(arr_mode), .read_mode(read_mode),
        .seg_en(seg_en), .test_ctl(test_ctl), .wr_addr(wr_addr),
        .wr_data(wr_data), .pulse_req(pulse_req), .pulse_fire(pulse_fire),
        .pulse_bad(pulse_bad)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops one expectation per bus read and compares mid-cycle
    always @(negedge clk) begin
        if (rst_n && bus_sel && !bus_we && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.tag, {16'h0, bus_rdata}, {16'h0, e.exp});
        end
    end

    task automatic set_acc(input logic v);
        @(posedge clk); #1;
        acc_wr = 1'b1; acc_val = v;
        @(posedge clk); #1;
        acc_wr = 1'b0;
    endtask

    task automatic bus_write(input logic [13:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [13:0] a, input logic [15:0] exp, input string tag);
        exp_t e;
        @(posedge clk); #1;
        e.exp = exp; e.tag = tag;
        sb_q.push_back(e);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        if (tag == "R3 array read") check("R3 arr_re", {31'h0, arr_re}, 32'h1);
        else check("R4 arr_re low in register view", {31'h0, arr_re}, 32'h0);
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic pulse(output logic f, output logic b);
        @(posedge clk); #1;
        pulse_req = 1'b1;
        @(posedge clk); #1;
        pulse_req = 1'b0;
        @(negedge clk);
        f = pulse_fire; b = pulse_bad;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic f, b;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 arr_mode", {31'h0, arr_mode}, 32'h1);
        check("R1 seg_en", {24'h0, seg_en}, 32'h0);
        check("R1 read_mode", {30'h0, read_mode}, 32'h0);
        check("R1 wr_data", {16'h0, wr_data}, 32'h0);
        check("R1 wr_addr", {18'h0, wr_addr}, 32'h0);
        check("R1 pulses", {30'h0, pulse_fire, pulse_bad}, 32'h0);

        // R2 switch to register view
        set_acc(1'b0);
        @(negedge clk);
        check("R2 arr_mode to 0", {31'h0, arr_mode}, 32'h0);

        // R5/R6/R7 segment control through an aliased address (offset 0)
        bus_write(14'h1230, 16'hA518);
        @(negedge clk);
        check("R6 seg_en", {24'h0, seg_en}, 32'hA5);
        check("R7 read_mode inverse-erase", {30'h0, read_mode}, 32'h3);
        bus_read(14'h3FFC, 16'hA518, "R4 alias read ctl");

        // R4/R5 other offsets through differing upper bits
        bus_write(14'h0005, 16'h1234);
        bus_write(14'h2002, 16'h2000);
        bus_write(14'h0ABF, 16'hBEEF);
        @(negedge clk);
        check("R5 test_ctl", {16'h0, test_ctl}, 32'h1234);
        check("R5 wr_addr", {18'h0, wr_addr}, 32'h2000);
        check("R5 wr_data", {16'h0, wr_data}, 32'hBEEF);
        bus_read(14'h3FFD, 16'h1234, "R4 read test");
        bus_read(14'h1236, 16'h2000, "R4 read waddr");
        bus_read(14'h0003, 16'hBEEF, "R4 read wdata");

        // R10: wr_addr 0x2000 -> segment 4, seg_en 0xA5 bit4=0
        pulse(f, b);
        check("R10 bad pulse flagged", {30'h0, f, b}, 32'h1);
        // R9: segment 0 enabled
        bus_write(14'h0002, 16'h0000);
        pulse(f, b);
        check("R9 pulse accepted", {30'h0, f, b}, 32'h2);
        // R9 top segment 7 (bit 15 set in 0xA5)
        bus_write(14'h0002, 16'h3800);
        pulse(f, b);
        check("R9 segment 7 accepted", {30'h0, f, b}, 32'h2);
        @(negedge clk);
        check("R9 pulse lasts one cycle", {30'h0, pulse_fire, pulse_bad}, 32'h0);

        // R7 other codes, R6 single-bit pattern
        bus_write(14'h0000, 16'h0108);
        @(negedge clk);
        check("R7 read_mode verify-zeros", {30'h0, read_mode}, 32'h1);
        check("R6 seg_en segment 0 only", {24'h0, seg_en}, 32'h01);
        bus_write(14'h0100, 16'h8010);
        @(negedge clk);
        check("R7 read_mode verify-ones", {30'h0, read_mode}, 32'h2);
        check("R6 seg_en segment 7 only", {24'h0, seg_en}, 32'h80);

        // R2/R3 back to array view
        set_acc(1'b1);
        @(negedge clk);
        check("R2 arr_mode to 1", {31'h0, arr_mode}, 32'h1);
        arr_rdata = 16'h5A5A;
        bus_read(14'h0000, 16'h5A5A, "R3 array read");
        arr_rdata = 16'hC3C3;
        bus_read(14'h0003, 16'hC3C3, "R3 array read");

        // R8: writes in array view are ignored
        bus_write(14'h0003, 16'hFFFF);
        bus_write(14'h0000, 16'h0000);
        @(negedge clk);
        check("R8 wr_data unchanged", {16'h0, wr_data}, 32'hBEEF);
        check("R8 seg_en unchanged", {24'h0, seg_en}, 32'h80);
        set_acc(1'b0);
        bus_read(14'h0000, 16'h8010, "R8 ctl unchanged");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule